// File: doc/BRIEF.md
# Variable-Rate Slot Request Generator

This block paces the codec side of a time-multiplexed audio link whose frames arrive at a fixed 48 kHz. Once per frame it decides, for each playback channel, whether the controller must put a fresh PCM sample into that channel's slot in the next outgoing frame. The request flags are active low. With variable-rate operation switched off, every channel asks for a sample in every frame. With it switched on, each channel is paced from its own programmable sample rate, so that the controller delivers, on average, exactly that many samples per second, spread evenly over the frames.

Each channel keeps a phase accumulator. At every frame strobe the channel's rate is added to it. Each time the total crosses 48000, the channel earns one sample credit. A credit turns into a request only while that channel's downstream FIFO reports a free entry. Credits earned while the FIFO is full are kept, up to a small limit, and are paid out one per frame once space returns. The slot valid tags received with each frame are compared against the requests that were outstanding, and any mismatch is reported as an overrun or an underrun pulse.

The link has no valid/ready handshake. Back-pressure enters only through the per-channel FIFO-space inputs, which withhold requests but never drop earned credit below the saturation limit. All other pins are plain control or status pins.

Top module: `vrate_slotreq_gen`

## Requirements
- R1: After reset, all request flags are high (nothing outstanding), the overrun and underrun outputs are 0, and every rate readback returns 48000.
- R2: While the variable-rate enable is 0, each frame strobe drives every request flag low in the cycle after the strobe edge.
- R3: While the variable-rate enable is 0, every rate readback returns 48000 and rate writes have no effect. After the enable is raised, a channel that was written while the enable was 0 still reads 48000.
- R4: While the variable-rate enable is 1, a write stores the rate for the addressed channel. The readback shows the new value in the cycle after the write edge. A written value of 0 or above 48000 is stored as 48000.
- R5: At each frame strobe, when variable-rate operation is enabled, the channel's rate is added to its accumulator. A total of 48000 or more subtracts 48000 and earns one credit. The request flag is updated only at a frame strobe edge and is held until the next one.
- R6: A channel programmed to 44100 with FIFO space always available requests in exactly 441 of 480 consecutive frames (starting from a cleared accumulator), and never goes two frames in a row without a request.
- R7: A channel whose FIFO-space input is 0 at a frame strobe does not request in that frame. Its earned credits are kept (saturating at 3) and are paid out as one request per frame while space is available.
- R8: A rate write clears that channel's accumulator to 0. If the write lands on a frame strobe edge, that frame's decision uses the old rate and old accumulator, and the accumulator still ends at 0.
- R9: At a frame strobe, a channel whose slot tag is valid while its request flag was high raises overrun for that channel for exactly one cycle.
- R10: At a frame strobe, a channel whose slot tag is invalid while its request flag was low raises underrun for that channel for exactly one cycle.
- R11: Channels are paced independently: rate, FIFO state and writes of one channel do not change the requests of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each link frame |
| vra_en | input | 1 | Variable-rate enable; 0 forces a request in every frame |
| rate_wr_en | input | 1 | Rate write strobe |
| rate_wr_ch | input | CH_W | Channel addressed by the write |
| rate_wr_data | input | RATE_W | Rate value in Hz to write |
| rate_rd_ch | input | CH_W | Channel selected for readback |
| rate_rd_data | output | RATE_W | Effective rate of the selected channel |
| slot_tag | input | NUM_CH | Valid tags of the incoming frame, sampled with frame_start |
| fifo_space | input | NUM_CH | 1 when the channel FIFO has a free entry |
| req_n | output | NUM_CH | Active-low sample request per channel |
| overrun | output | NUM_CH | Pulse: a valid sample arrived with no request outstanding |
| underrun | output | NUM_CH | Pulse: a request was outstanding but the slot was not valid |

## Verification
The bench aims at the corner cases where a pacing bug shows up as a wrong count or a wrong frame position. The 44.1 kHz stream over a full 480-frame period catches an off-by-one compare (>= against >), which would give 440 or 442 requests or bunch them together. Rates of 0 and above 48000 show whether the clamp is missing, which would give a silent channel or a double rate. Long FIFO-full stretches followed by release show whether credit is lost or fails to saturate: the payout burst comes out too short, too long, or missing. Writes that coincide with a frame strobe, and repeated writes of the same rate, show whether the accumulator is not cleared or the old and new rates are mixed, which moves the next request by a frame.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // Per-channel pacing decision taken at a frame strobe
  typedef enum logic [1:0] {
    PACE_FORCED   = 2'd0,  // variable rate off: request every frame
    PACE_ISSUE    = 2'd1,  // credit available and FIFO has room
    PACE_WITHHOLD = 2'd2,  // credit available but FIFO full
    PACE_IDLE     = 2'd3   // no credit this frame
  } pace_e;

endpackage

// File: rtl/srg_rate_regs.sv
module srg_rate_regs #(
  parameter int NUM_CH   = 4,
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vra_en,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [RATE_W-1:0]              wr_data,
  input  logic [CH_W-1:0]                rd_ch,
  output logic [RATE_W-1:0]              rd_data,
  output logic [NUM_CH-1:0][RATE_W-1:0]  rates,
  output logic [NUM_CH-1:0]              wr_hit
);

  localparam logic [RATE_W-1:0] FULL_RATE = RATE_W'(FRAME_HZ);
  localparam logic [CH_W:0]     CH_COUNT  = (CH_W+1)'(NUM_CH);

  function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] v);
    if (v == '0 || v > FULL_RATE) return FULL_RATE;
    return v;
  endfunction

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_hit[g] = vra_en && wr_en && (wr_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       rates[g] <= FULL_RATE;
      else if (!vra_en) rates[g] <= FULL_RATE;
      else if (wr_hit[g]) rates[g] <= clamp_rate(wr_data);
    end

    // R4
    rate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rates[g] != '0) && (rates[g] <= FULL_RATE));

    // R3
    rate_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vra_en |=> (rates[g] == FULL_RATE));
  end

  always_comb begin
    rd_data = FULL_RATE;
    if (vra_en && ({1'b0, rd_ch} < CH_COUNT)) rd_data = rates[rd_ch];
  end

endmodule

// File: rtl/srg_pacer.sv
module srg_pacer
  import srg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int CREDIT_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_start,
  input  logic                           vra_en,
  input  logic [NUM_CH-1:0][RATE_W-1:0]  rates,
  input  logic [NUM_CH-1:0]              clr_acc,
  input  logic [NUM_CH-1:0]              fifo_space,
  output logic [NUM_CH-1:0]              req_n
);

  localparam int                ACC_W    = RATE_W + 1;
  localparam logic [ACC_W-1:0]  WRAP     = ACC_W'(FRAME_HZ);
  localparam logic [CREDIT_W-1:0] CRED_MAX = '1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [ACC_W-1:0]    acc_q, sum, acc_nxt;
    logic [CREDIT_W-1:0] cred_q, cred_inc, cred_nxt;
    logic                tick;
    pace_e               pace;

    always_comb begin
      sum      = acc_q + {1'b0, rates[g]};
      tick     = (sum >= WRAP);
      acc_nxt  = tick ? (sum - WRAP) : sum;
      cred_inc = (tick && (cred_q != CRED_MAX)) ? (cred_q + CREDIT_W'(1)) : cred_q;
      if (!vra_en)               pace = PACE_FORCED;
      else if (cred_inc == '0)   pace = PACE_IDLE;
      else if (fifo_space[g])    pace = PACE_ISSUE;
      else                       pace = PACE_WITHHOLD;
      cred_nxt = (pace == PACE_ISSUE) ? (cred_inc - CREDIT_W'(1)) : cred_inc;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q    <= '0;
        cred_q   <= '0;
        req_n[g] <= 1'b1;
      end else if (!vra_en) begin
        acc_q  <= '0;
        cred_q <= '0;
        if (frame_start) req_n[g] <= 1'b0;
      end else begin
        if (frame_start) begin
          acc_q    <= acc_nxt;
          cred_q   <= cred_nxt;
          req_n[g] <= (pace != PACE_ISSUE);
        end
        if (clr_acc[g]) acc_q <= '0;
      end
    end

    // R7
    withhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && vra_en && !fifo_space[g] |=> req_n[g]);

    // R5
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < WRAP);

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_acc[g] |=> (acc_q == '0));
  end

endmodule

// File: rtl/srg_tag_check.sv
module srg_tag_check #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] req_n,
  input  logic [NUM_CH-1:0] slot_tag,
  output logic [NUM_CH-1:0] overrun,
  output logic [NUM_CH-1:0] underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun  <= '0;
      underrun <= '0;
    end else if (frame_start) begin
      overrun  <= slot_tag & req_n;
      underrun <= ~slot_tag & ~req_n;
    end else begin
      overrun  <= '0;
      underrun <= '0;
    end
  end

  // R9
  ovr_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun != '0) |-> $past(frame_start));

  // R10
  und_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun != '0) |-> $past(frame_start));

  // R10
  und_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (&req_n) |=> (underrun == '0));

endmodule

// File: rtl/vrate_slotreq_gen.sv
module vrate_slotreq_gen #(
  parameter int NUM_CH   = 4,
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int CREDIT_W = 2,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              vra_en,
  input  logic              rate_wr_en,
  input  logic [CH_W-1:0]   rate_wr_ch,
  input  logic [RATE_W-1:0] rate_wr_data,
  input  logic [CH_W-1:0]   rate_rd_ch,
  output logic [RATE_W-1:0] rate_rd_data,
  input  logic [NUM_CH-1:0] slot_tag,
  input  logic [NUM_CH-1:0] fifo_space,
  output logic [NUM_CH-1:0] req_n,
  output logic [NUM_CH-1:0] overrun,
  output logic [NUM_CH-1:0] underrun
);

  logic [NUM_CH-1:0][RATE_W-1:0] rates;
  logic [NUM_CH-1:0]             wr_hit;

  srg_rate_regs #(
    .NUM_CH(NUM_CH), .RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ), .CH_W(CH_W)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .vra_en  (vra_en),
    .wr_en   (rate_wr_en),
    .wr_ch   (rate_wr_ch),
    .wr_data (rate_wr_data),
    .rd_ch   (rate_rd_ch),
    .rd_data (rate_rd_data),
    .rates   (rates),
    .wr_hit  (wr_hit)
  );

  srg_pacer #(
    .NUM_CH(NUM_CH), .RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ), .CREDIT_W(CREDIT_W)
  ) i_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .vra_en      (vra_en),
    .rates       (rates),
    .clr_acc     (wr_hit),
    .fifo_space  (fifo_space),
    .req_n       (req_n)
  );

  srg_tag_check #(.NUM_CH(NUM_CH)) i_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .req_n       (req_n),
    .slot_tag    (slot_tag),
    .overrun     (overrun),
    .underrun    (underrun)
  );

  // R2
  forced_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !vra_en |=> (req_n == '0));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(req_n));

endmodule

// File: tb/test_vrate_slotreq_gen.sv
module test_vrate_slotreq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int FULL = 48000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, vra = 1'b0, we = 1'b0;
  logic [1:0]  wch = '0, rdch = '0;
  logic [15:0] wdata = '0;
  logic [NCH-1:0] tag = '0, space = '1;
  logic [15:0] rd_data;
  logic [NCH-1:0] req_n, ovr, und;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur = "R1";

  // reference model state
  int m_rate[NCH];
  int m_acc[NCH];
  int m_cred[NCH];
  bit [NCH-1:0] m_req_n = '1, m_ovr = '0, m_und = '0;
  logic [NCH-1:0] last_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrate_slotreq_gen i_vrate_slotreq_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .vra_en(vra),
    .rate_wr_en(we), .rate_wr_ch(wch), .rate_wr_data(wdata),
    .rate_rd_ch(rdch), .rate_rd_data(rd_data),
    .slot_tag(tag), .fifo_space(space),
    .req_n(req_n), .overrun(ovr), .underrun(und)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_rate[c] = FULL; m_acc[c] = 0; m_cred[c] = 0;
    end
    m_req_n = '1; m_ovr = '0; m_und = '0;
  endtask

  task automatic model_update();
    bit [NCH-1:0] o = '0, u = '0;
    if (!rst_n) begin model_reset(); return; end
    if (fs)
      for (int c = 0; c < NCH; c++) begin
        o[c] = tag[c] && m_req_n[c];
        u[c] = !tag[c] && !m_req_n[c];
      end
    for (int c = 0; c < NCH; c++) begin
      if (!vra) begin
        m_rate[c] = FULL; m_acc[c] = 0; m_cred[c] = 0;
        if (fs) m_req_n[c] = 1'b0;
      end else begin
        if (fs) begin
          int s, cr;
          s = m_acc[c] + m_rate[c];
          cr = m_cred[c];
          if (s >= FULL) begin s -= FULL; cr++; end
          if (cr > 3) cr = 3;
          if (cr > 0 && space[c]) begin m_req_n[c] = 1'b0; cr--; end
          else m_req_n[c] = 1'b1;
          m_acc[c] = s; m_cred[c] = cr;
        end
        if (we && wch == c) begin
          m_rate[c] = (wdata == 0 || wdata > FULL) ? FULL : int'(wdata);
          m_acc[c] = 0;
        end
      end
    end
    m_ovr = o; m_und = u;
  endtask

  task automatic compare();
    int exp_rd;
    exp_rd = vra ? m_rate[rdch] : FULL;
    check(cur, "req_n", int'(req_n), int'(m_req_n));
    check(cur, "overrun", int'(ovr), int'(m_ovr));
    check(cur, "underrun", int'(und), int'(m_und));
    check(cur, "rate readback", int'(rd_data), exp_rd);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic frame(input logic [NCH-1:0] t, input logic [NCH-1:0] sp);
    fs = 1'b1; tag = t; space = sp;
    step();
    last_req = req_n;
    fs = 1'b0;
    repeat (3) step();
  endtask

  task automatic wr(input int ch, input int val);
    we = 1'b1; wch = 2'(ch); wdata = 16'(val);
    step();
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt0, cnt1, cnt2, cnt3, gap, maxgap;
    model_reset();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1", "req_n after reset", int'(req_n), 'hF);
    check("R1", "overrun after reset", int'(ovr), 0);
    check("R1", "readback after reset", int'(rd_data), FULL);

    // R2 / R9 / R10 with variable rate off
    cur = "R2";
    frame(4'hF, 4'hF);
    check("R2", "forced req frame 1", int'(last_req), 0);
    check("R9", "overrun with no outstanding request", int'(ovr) , 0); // pulse already gone
    frame(4'h5, 4'h0);
    check("R2", "forced req ignores fifo", int'(last_req), 0);
    frame(4'h0, 4'hF);
    // R3 writes ignored while disabled
    cur = "R3";
    wr(1, 12345);
    rdch = 2'd1; step();
    check("R3", "readback while disabled", int'(rd_data), FULL);
    vra = 1'b1; step();
    check("R3", "readback after enable", int'(rd_data), FULL);

    // R9 / R10 explicit pulse positions
    cur = "R10";
    fs = 1'b1; tag = 4'h3; step();
    check("R10", "underrun on invalid tags", int'(und), 'hC);
    fs = 1'b0; tag = '0; step();
    check("R10", "underrun one cycle", int'(und), 0);

    // R4 writes and clamping
    cur = "R4";
    wr(0, 44100); wr(1, 0); wr(2, 60000); wr(3, 8000);
    rdch = 2'd0; step(); check("R4", "ch0 rate", int'(rd_data), 44100);
    rdch = 2'd1; step(); check("R4", "ch1 clamp zero", int'(rd_data), FULL);
    rdch = 2'd2; step(); check("R4", "ch2 clamp high", int'(rd_data), FULL);
    rdch = 2'd3; step(); check("R4", "ch3 rate", int'(rd_data), 8000);

    // R5 / R6 / R11 full 480-frame period; controller follows requests
    cur = "R6";
    wr(0, 44100); wr(3, 8000);   // restart accumulators from zero
    cnt0 = 0; cnt1 = 0; cnt2 = 0; cnt3 = 0; gap = 0; maxgap = 0;
    for (int f = 0; f < 480; f++) begin
      frame(~req_n, 4'hF);
      if (!last_req[0]) begin cnt0++; gap = 0; end
      else begin gap++; if (gap > maxgap) maxgap = gap; end
      if (!last_req[1]) cnt1++;
      if (!last_req[2]) cnt2++;
      if (!last_req[3]) cnt3++;
    end
    check("R6", "44100 requests per 480 frames", cnt0, 441);
    check("R6", "longest request gap", maxgap, 1);
    check("R4", "clamped channel requests every frame", cnt1 + cnt2, 960);
    check("R5", "8000 requests per 480 frames", cnt3, 80);

    // R7 back-pressure with credit saturation
    cur = "R7";
    wr(3, 12000);
    cnt3 = 0;
    for (int f = 0; f < 20; f++) begin
      frame(~req_n, 4'h7);
      if (!last_req[3]) cnt3++;
    end
    check("R7", "no request while fifo full", cnt3, 0);
    cnt3 = 0;
    for (int f = 0; f < 3; f++) begin
      frame(~req_n, 4'hF);
      if (!last_req[3]) cnt3++;
    end
    check("R7", "saved credits paid out", cnt3, 3);

    // R8 write clears accumulator
    cur = "R8";
    wr(0, 24000);
    frame(~req_n, 4'hF);               // acc 24000, no request
    check("R8", "first frame after write", int'(last_req[0]), 1);
    wr(0, 24000);                      // clear again
    frame(~req_n, 4'hF);
    check("R8", "cleared accumulator delays request", int'(last_req[0]), 1);
    frame(~req_n, 4'hF);
    check("R8", "request after second frame", int'(last_req[0]), 0);
    frame(~req_n, 4'hF);               // acc 24000 again
    we = 1'b1; wch = 2'd0; wdata = 16'd24000;
    fs = 1'b1; tag = ~req_n; step();   // same-edge write: old state ticks
    we = 1'b0; fs = 1'b0;
    check("R8", "same-edge write uses old state", int'(req_n[0]), 0);
    repeat (3) step();
    frame(~req_n, 4'hF);
    check("R8", "accumulator zero after same-edge write", int'(last_req[0]), 1);

    // R11 mixed random traffic
    cur = "R11";
    for (int f = 0; f < 300; f++) begin
      if ($urandom_range(0, 5) == 0) begin
        we = 1'b1; wch = 2'($urandom_range(0, 3));
        wdata = 16'($urandom_range(0, 65535));
      end
      rdch = 2'($urandom_range(0, 3));
      frame(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      we = 1'b0;
    end

    // R2 / R3 after disabling again
    cur = "R2";
    vra = 1'b0; step();
    check("R3", "readback forced on disable", int'(rd_data), FULL);
    frame(4'h0, 4'h0);
    check("R2", "forced requests after disable", int'(last_req), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule